// File: doc/BRIEF.md
# Extended Multiply Divide Unit

This unit performs the long arithmetic operations of a 16-bit register machine. The machine has three data registers: D, X and Y. The unit implements three divides and one multiply:

- a signed word divide of D by X;
- an unsigned long divide of the 32-bit pair Y:D by X;
- a signed long divide of Y:D by X;
- a signed multiply of D by Y, whose 32-bit product is written to the pair Y:D.

The surrounding core supplies the current D, X and Y values and an operation code with a one-cycle `start`. Some cycles later the unit pulses `done`. At that point it presents the new values for all three registers, together with the N, Z, V and C condition flags. Registers that an operation does not write are returned unchanged, so the core can write back all three registers.

The divides use a restoring shift-subtract datapath that retires one quotient bit per clock. Signed divides work on magnitudes, and the signs are applied in a final state. The controller has five states:

- **IDLE** waits for a start.
- **DIVIDE** runs the shift-subtract iterations.
- **SIGN** applies the signs and flags.
- **MUL** writes the product.
- **ZERO** handles a divisor of zero.

Its transitions are:

- *accept-mul* (IDLE→MUL)
- *accept-zero* (IDLE→ZERO, divide with X = 0)
- *accept-div* (IDLE→DIVIDE)
- *iterate* (DIVIDE→DIVIDE)
- *last-bit* (DIVIDE→SIGN)
- *finish* (SIGN, MUL or ZERO → IDLE)

Top module: `xmd_unit`

## Requirements
- R1: With `op` = 0 (signed word divide), the quotient of D / X goes to `x_out`, the remainder goes to `d_out`, and `y_out` returns `y_in`.
- R2: With `op` = 1 (unsigned long divide), {Y,D} / X is computed unsigned. The low 16 bits of the quotient go to `y_out`, the remainder goes to `d_out`, and `x_out` returns `x_in`.
- R3: With `op` = 2 (signed long divide), {Y,D} / X is computed signed. The low 16 bits of the quotient go to `y_out`, the remainder goes to `d_out`, and `x_out` returns `x_in`.
- R4: Signed quotients are truncated toward zero, and a nonzero remainder has the sign of the dividend.
- R5: A divide with X = 0 sets C and clears N, Z and V. In that case `d_out`, `x_out` and `y_out` equal the operands, and `done` follows one clock after the start edge.
- R6: A divide with nonzero X clears C. It sets Z exactly when the full quotient is zero, and N copies quotient bit 15.
- R7: V is set when the quotient does not fit in 16 bits. For op 1 this means the quotient exceeds 0xFFFF. For ops 0 and 2 it means the quotient lies outside -32768..32767.
- R8: With `op` = 3 (signed multiply), the product of D and Y goes to {`y_out`,`d_out`} and `x_out` returns `x_in`. Z flags a zero product, N copies product bit 31, C copies product bit 15, and V is 0. `done` follows one clock after the start edge.
- R9: A divide with nonzero X raises `done` 33 clock edges after the edge that accepted `start`.
- R10: `busy` is high from the accepting edge until the edge that raises `done`. A `start` seen while `busy` is high is ignored.
- R11: `done` is a one-cycle pulse. The result outputs and flags change only on the edge that raises `done`, and hold until the next completion.
- R12: While `rst_n` is low, `busy`, `done`, all result outputs and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 0 signed word divide, 1 unsigned long divide, 2 signed long divide, 3 signed multiply |
| d_in | input | 16 | Current D register |
| x_in | input | 16 | Current X register |
| y_in | input | 16 | Current Y register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| d_out | output | 16 | New D register value |
| x_out | output | 16 | New X register value |
| y_out | output | 16 | New Y register value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry / divide-by-zero flag |

## Verification
The completion of one operation and the acceptance of the next can land in the same cycle. The FSM is back in IDLE during the `done` cycle, so a `start` held in that cycle is taken on the following edge.

The bench issues every new operation in the cycle its reference model predicts `done`. It then compares, on every clock, the held results of the finished operation and the latency and flags of the new one.

A second case is a `start` arriving while a divide is still running. The bench drives a multiply request for three busy cycles. It judges that the divide's results, rather than a product, appear at the expected edge.

// File: rtl/xmd_pkg.sv
package xmd_pkg;

    typedef enum logic [1:0] {
        OP_SDIV_W = 2'd0,
        OP_UDIV_L = 2'd1,
        OP_SDIV_L = 2'd2,
        OP_SMUL   = 2'd3
    } xmd_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIVIDE,
        ST_SIGN,
        ST_MUL,
        ST_ZERO
    } xmd_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } xmd_flags_t;

endpackage

// File: rtl/xmd_divstep.sv
// One restoring shift-subtract step: brings the next dividend bit into the
// partial remainder and subtracts the divisor when it fits.
module xmd_divstep #(
    parameter int DW = 16,
    parameter int QW = 32
) (
    input  logic [DW-1:0] rem_i,
    input  logic [QW-1:0] quo_i,
    input  logic [DW-1:0] div_i,
    output logic [DW-1:0] rem_o,
    output logic [QW-1:0] quo_o
);
    logic [DW:0] trial;
    logic [DW:0] diff;

    always_comb begin
        trial = {rem_i, quo_i[QW-1]};
        diff  = trial - {1'b0, div_i};
        if (trial >= {1'b0, div_i}) begin
            rem_o = diff[DW-1:0];
            quo_o = {quo_i[QW-2:0], 1'b1};
        end else begin
            rem_o = trial[DW-1:0];
            quo_o = {quo_i[QW-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/xmd_signfix.sv
// Applies signs to the magnitude quotient and remainder, and derives the
// divide flags, including the range check for overflow.
module xmd_signfix
    import xmd_pkg::*;
#(
    parameter int DW = 16,
    parameter int QW = 32
) (
    input  xmd_op_e       op_i,
    input  logic [QW-1:0] q_mag,
    input  logic [DW-1:0] r_mag,
    input  logic          q_neg,
    input  logic          r_neg,
    output logic [DW-1:0] quo_o,
    output logic [DW-1:0] rem_o,
    output xmd_flags_t    flags_o
);
    logic [QW:0] q_s;
    logic        fits_s;
    logic        fits_u;

    always_comb begin
        q_s       = q_neg ? -{1'b0, q_mag} : {1'b0, q_mag};
        quo_o     = q_s[DW-1:0];
        rem_o     = r_neg ? -r_mag : r_mag;
        fits_s    = (&q_s[QW:DW-1]) | ~(|q_s[QW:DW-1]);
        fits_u    = ~(|q_mag[QW-1:DW]);
        flags_o.n = q_s[DW-1];
        flags_o.z = ~(|q_mag);
        flags_o.v = (op_i == OP_UDIV_L) ? ~fits_u : ~fits_s;
        flags_o.c = 1'b0;
    end
endmodule

// File: rtl/xmd_mul.sv
// Signed word multiply with its flag rules.
module xmd_mul
    import xmd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    output logic [2*DW-1:0] prod_o,
    output xmd_flags_t      flags_o
);
    logic [2*DW-1:0] ea;
    logic [2*DW-1:0] eb;

    always_comb begin
        ea        = {{DW{a_i[DW-1]}}, a_i};
        eb        = {{DW{b_i[DW-1]}}, b_i};
        prod_o    = ea * eb;
        flags_o.z = ~(|prod_o);
        flags_o.n = prod_o[2*DW-1];
        flags_o.c = prod_o[DW-1];
        flags_o.v = 1'b0;
    end
endmodule

// File: rtl/xmd_unit.sv
module xmd_unit
    import xmd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [DW-1:0] d_in,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] d_out,
    output logic [DW-1:0] x_out,
    output logic [DW-1:0] y_out,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c
);
    localparam int QW = 2 * DW;
    localparam int CW = $clog2(QW + 1);
    localparam logic [CW-1:0] LAST = CW'(QW - 1);

    xmd_state_e state, nxt;
    xmd_op_e    op_in, op_q;
    logic [DW-1:0] d_q, x_q, y_q, div_q, rem_q;
    logic [QW-1:0] quo_q;
    logic [CW-1:0] cnt_q;
    logic          q_neg_q, r_neg_q;

    // operand conditioning at the start edge
    logic          accept, is_div_in, signed_in, dvd_neg, dsr_neg;
    logic [QW-1:0] dvd_in, dvd_mag;
    logic [DW-1:0] dsr_mag;

    always_comb begin
        op_in     = xmd_op_e'(op);
        accept    = start && (state == ST_IDLE);
        is_div_in = (op_in != OP_SMUL);
        signed_in = (op_in == OP_SDIV_W) || (op_in == OP_SDIV_L);
        dvd_in    = (op_in == OP_SDIV_W) ? {{DW{d_in[DW-1]}}, d_in} : {y_in, d_in};
        dvd_neg   = signed_in && dvd_in[QW-1];
        dvd_mag   = dvd_neg ? -dvd_in : dvd_in;
        dsr_neg   = signed_in && x_in[DW-1];
        dsr_mag   = dsr_neg ? -x_in : x_in;
    end

    // datapath pieces
    logic [DW-1:0] step_rem, fix_q, fix_r;
    logic [QW-1:0] step_quo, prod;
    xmd_flags_t    fix_f, mul_f;

    xmd_divstep #(.DW(DW), .QW(QW)) u_step (
        .rem_i(rem_q), .quo_i(quo_q), .div_i(div_q),
        .rem_o(step_rem), .quo_o(step_quo)
    );

    xmd_signfix #(.DW(DW), .QW(QW)) u_fix (
        .op_i(op_q), .q_mag(quo_q), .r_mag(rem_q),
        .q_neg(q_neg_q), .r_neg(r_neg_q),
        .quo_o(fix_q), .rem_o(fix_r), .flags_o(fix_f)
    );

    xmd_mul #(.DW(DW)) u_mul (
        .a_i(d_q), .b_i(y_q), .prod_o(prod), .flags_o(mul_f)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (!is_div_in)      nxt = ST_MUL;     // accept-mul
                    else if (x_in == '0) nxt = ST_ZERO;    // accept-zero
                    else                 nxt = ST_DIVIDE;  // accept-div
                end
            end
            ST_DIVIDE: nxt = (cnt_q == LAST) ? ST_SIGN : ST_DIVIDE;
            ST_SIGN:   nxt = ST_IDLE;
            ST_MUL:    nxt = ST_IDLE;
            ST_ZERO:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    assign busy = (state != ST_IDLE);

    // working registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_SDIV_W;
            d_q     <= '0;
            x_q     <= '0;
            y_q     <= '0;
            div_q   <= '0;
            rem_q   <= '0;
            quo_q   <= '0;
            cnt_q   <= '0;
            q_neg_q <= 1'b0;
            r_neg_q <= 1'b0;
            done    <= 1'b0;
            d_out   <= '0;
            x_out   <= '0;
            y_out   <= '0;
            flag_n  <= 1'b0;
            flag_z  <= 1'b0;
            flag_v  <= 1'b0;
            flag_c  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_q    <= op_in;
                        d_q     <= d_in;
                        x_q     <= x_in;
                        y_q     <= y_in;
                        div_q   <= dsr_mag;
                        quo_q   <= dvd_mag;
                        rem_q   <= '0;
                        cnt_q   <= '0;
                        q_neg_q <= dvd_neg ^ dsr_neg;
                        r_neg_q <= dvd_neg;
                    end
                end
                ST_DIVIDE: begin
                    rem_q <= step_rem;
                    quo_q <= step_quo;
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_SIGN: begin
                    done   <= 1'b1;
                    d_out  <= fix_r;
                    {flag_n, flag_z, flag_v, flag_c} <= fix_f;
                    if (op_q == OP_SDIV_W) begin
                        x_out <= fix_q;
                        y_out <= y_q;
                    end else begin
                        x_out <= x_q;
                        y_out <= fix_q;
                    end
                end
                ST_MUL: begin
                    done  <= 1'b1;
                    d_out <= prod[DW-1:0];
                    y_out <= prod[QW-1:DW];
                    x_out <= x_q;
                    {flag_n, flag_z, flag_v, flag_c} <= mul_f;
                end
                ST_ZERO: begin
                    done   <= 1'b1;
                    d_out  <= d_q;
                    x_out  <= x_q;
                    y_out  <= y_q;
                    flag_n <= 1'b0;
                    flag_z <= 1'b0;
                    flag_v <= 1'b0;
                    flag_c <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R11: results move only with the done pulse
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(d_out) && $stable(x_out) && $stable(y_out)));

    // R11: done never lasts two cycles
    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: zero divisor reports carry and completes next edge
    assert_zero_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ZERO) |=> (done && flag_c && !flag_v && !flag_z));

    // R4: partial remainder stays below the divisor magnitude
    assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIVIDE) |-> (rem_q < div_q));

    // R10: a start during an operation leaves the captured request alone
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(op_q) && $stable(d_q) && $stable(x_q)));

    // R8: multiply finishes next edge with V clear and X passed through
    assert_mul_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MUL) |=> (done && !flag_v && (x_out == $past(x_q))));

endmodule

// File: tb/xmd_unit_tb_top.sv
module xmd_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_LAT    = 33;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  op;
    logic [15:0] d_in, x_in, y_in;
    logic        busy, done;
    logic [15:0] d_out, x_out, y_out;
    logic        flag_n, flag_z, flag_v, flag_c;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xmd_unit #(.DW(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .d_in(d_in), .x_in(x_in), .y_in(y_in),
        .busy(busy), .done(done),
        .d_out(d_out), .x_out(x_out), .y_out(y_out),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit started = 0;
    bit finished = 0;

    // reference model state
    bit          m_busy, m_done;
    int          m_cnt;
    logic [15:0] m_d, m_x, m_y;
    logic        m_n, m_z, m_v, m_c;
    string       m_tag;
    // pending result of the accepted operation
    logic [15:0] p_d, p_x, p_y;
    logic        p_n, p_z, p_v, p_c;
    int          p_lat;
    string       p_tag;

    task model_eval(input int opv, input logic [15:0] d, input logic [15:0] x,
                    input logic [15:0] y);
        longint dvd, dsr, q, r, pr;
        logic [63:0] qv, rv, pv;
        if (opv == 3) begin
            pr = longint'($signed(d)) * longint'($signed(y));
            pv = pr;
            p_d = pv[15:0]; p_y = pv[31:16]; p_x = x;
            p_z = (pv[31:0] == 32'd0); p_n = pv[31]; p_c = pv[15]; p_v = 1'b0;
            p_lat = 1; p_tag = "R8";
        end else if (x == 16'd0) begin
            p_d = d; p_x = x; p_y = y;
            p_n = 0; p_z = 0; p_v = 0; p_c = 1;
            p_lat = 1; p_tag = "R5";
        end else begin
            if (opv == 0) begin
                dvd = longint'($signed(d));
                dsr = longint'($signed(x));
            end else if (opv == 1) begin
                dvd = longint'({y, d});
                dsr = longint'(x);
            end else begin
                dvd = longint'($signed({y, d}));
                dsr = longint'($signed(x));
            end
            q = dvd / dsr;
            r = dvd % dsr;
            qv = q; rv = r;
            p_c = 0;
            p_z = (q == 0);
            p_n = qv[15];
            p_v = (opv == 1) ? (q > 65535) : (q > 32767 || q < -32768);
            p_d = rv[15:0];
            if (opv == 0) begin
                p_x = qv[15:0]; p_y = y; p_tag = "R1 R4 R6 R7";
            end else begin
                p_y = qv[15:0]; p_x = x;
                p_tag = (opv == 1) ? "R2 R6 R7" : "R3 R4 R6 R7";
            end
            p_lat = DIV_LAT;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0;
            m_d = 0; m_x = 0; m_y = 0;
            m_n = 0; m_z = 0; m_v = 0; m_c = 0;
            m_tag = "R12";
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1;
                    m_d = p_d; m_x = p_x; m_y = p_y;
                    m_n = p_n; m_z = p_z; m_v = p_v; m_c = p_c;
                    m_tag = p_tag;
                end
            end else if (start) begin
                model_eval(int'(op), d_in, x_in, y_in);
                m_cnt = p_lat;
                m_busy = 1;
            end
        end
        started = 1;
    end

    task chk(input string tag, input string name, input logic [15:0] act,
             input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R9 R10 R12", "busy", {15'd0, busy}, {15'd0, m_busy});
            chk("R9 R11 R12", "done", {15'd0, done}, {15'd0, m_done});
            chk(m_tag, "d_out", d_out, m_d);
            chk(m_tag, "x_out", x_out, m_x);
            chk(m_tag, "y_out", y_out, m_y);
            chk(m_tag, "flags", {12'd0, flag_n, flag_z, flag_v, flag_c},
                {12'd0, m_n, m_z, m_v, m_c});
        end
    end

    task finish_run;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task issue(input int opv, input logic [15:0] d, input logic [15:0] x,
               input logic [15:0] y);
        start = 1; op = 2'(opv); d_in = d; x_in = x; y_in = y;
        @(negedge clk);
        start = 0;
    endtask

    task wait_done;
        while (!m_done) @(negedge clk);
    endtask

    task run(input int opv, input logic [15:0] d, input logic [15:0] x,
             input logic [15:0] y);
        issue(opv, d, x, y);
        wait_done();
    endtask

    initial begin
        rst_n = 0; start = 0; op = 0; d_in = 0; x_in = 0; y_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 R4: signed word divides, sign combinations
        run(0, 16'd100, 16'd7, 16'h1234);
        run(0, -16'sd100, 16'd7, 16'h0);
        run(0, 16'd100, -16'sd7, 16'h0);
        run(0, -16'sd100, -16'sd7, 16'hBEEF);
        // R7: only overflow case of the word divide
        run(0, 16'h8000, 16'hFFFF, 16'h0);
        // R6: zero quotient
        run(0, 16'd3, 16'd5, 16'h0);
        // R2: unsigned long divides
        run(1, 16'h2345, 16'h0010, 16'h0001);
        run(1, 16'hFFFF, 16'h0001, 16'hFFFF);
        run(1, 16'h0000, 16'h0002, 16'h0001);
        run(1, 16'hFFFF, 16'hFFFF, 16'hFFFE);
        // R3: signed long divides
        run(2, 16'hBDC0, 16'd300, 16'hFFF0);
        run(2, 16'h0000, 16'hFFFF, 16'h8000);
        run(2, 16'h1170, -16'sd3, 16'h0001);
        run(2, 16'h0001, 16'h8000, 16'hFFFF);
        // R5: zero divisor on each divide
        run(0, 16'h1111, 16'h0, 16'h2222);
        run(1, 16'h3333, 16'h0, 16'h4444);
        run(2, 16'h5555, 16'h0, 16'h6666);
        // R8: multiplies
        run(3, -16'sd3, 16'hAAAA, 16'd5);
        run(3, 16'd0, 16'h1, 16'h7FFF);
        run(3, 16'h7FFF, 16'h2, 16'h7FFF);
        run(3, 16'h8000, 16'h3, 16'h8000);
        // R10: start while busy is ignored
        issue(1, 16'h0100, 16'h0010, 16'h0000);
        repeat (5) @(negedge clk);
        start = 1; op = 2'd3; d_in = 16'd9; x_in = 16'd0; y_in = 16'd9;
        repeat (3) @(negedge clk);
        start = 0;
        wait_done();
        // R11: back-to-back starts on the done cycle
        run(3, 16'd7, 16'd1, 16'd6);
        run(2, 16'hFFFF, 16'd2, 16'hFFFF);
        run(0, 16'd9, 16'd0, 16'd1);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule